// File: doc/BRIEF.md
# Downstream Channel Connection Controller

This block decides which of two downstream two-wire bus segments are joined to the upstream segment. A master issues a connect command as a one-cycle strobe with a request bit for each channel. Any combination is accepted, including none and both. Unless a force bit is set, a requested channel is granted only if its idle flag is high in the command cycle. The idle flag means that both its clock and data lines read high. A request for a busy channel is refused. The refusal drops a status bit and emits a one-cycle fault event toward the alert logic.

The granted pattern drives the switch enables, which hold until the next accepted command. The upstream/downstream buffers are active only while at least one switch is closed and no stuck-low condition is reported. The ready pull-down is released exactly while the buffers are active. Driving enable low returns every control bit to its disconnected default, and commands and status writes are then ignored.

Top module: `dsc_link_ctrl`

## Requirements
- R1: Bit i of `cmd_req` (bit 0 for channel 1, bit 1 for channel 2) requests channel i. The values 00, 01, 10 and 11 are all legal. A granted channel shows on `sw_en[i]` one clock after the strobe.
- R2: With `force_conn` low, a requested channel is granted only if `chan_idle[i]` is 1 in the strobe cycle.
- R3: When both channels are requested and only one is idle, only the idle one is granted and the other switch opens.
- R4: With `force_conn` high, `sw_en` takes `cmd_req` exactly, whatever the idle flags. No fault is raised.
- R5: When `force_conn` is low and some requested channel is not idle, `conn_ok` goes to 0 and `fault_pulse` is 1 for exactly the next cycle.
- R6: `buf_active` is 1 exactly when some `sw_en` bit is 1 and `stuck_low` is 0. It follows `stuck_low` in the same cycle.
- R7: `ready_pull_low` is always the inverse of `buf_active`.
- R8: While `enable` is 0, in the next cycle `sw_en` is 00, `conn_ok` is 1 and `fault_pulse` is 0. Strobes and `reg0_wr` are ignored.
- R9: `conn_ok` returns to 1 after a `reg0_wr`, or after a strobe that raises no fault. When a `reg0_wr` and a faulting strobe arrive in the same cycle, the fault wins.
- R10: Between accepted strobes, `sw_en` holds its value even if the idle flags change.
- R11: After reset, `sw_en` is 00, `buf_active` is 0, `ready_pull_low` is 1, `conn_ok` is 1 and `fault_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces defaults |
| cmd_valid | input | 1 | Connect command strobe |
| cmd_req | input | 2 | Requested channels |
| chan_idle | input | 2 | Per-channel idle flag (clock and data high) |
| force_conn | input | 1 | Override: connect regardless of idle state |
| stuck_low | input | 1 | Stuck-low condition present |
| reg0_wr | input | 1 | Status register write (clears the fault) |
| sw_en | output | 2 | Downstream switch enables |
| buf_active | output | 1 | Upstream/downstream buffers active |
| ready_pull_low | output | 1 | Ready open-drain pull-down on |
| conn_ok | output | 1 | Failed-connection status, 0 after a refusal |
| fault_pulse | output | 1 | One-cycle connection fault event |

## Verification
The hardest situation to reach from the ports is a collision of events in one cycle. Examples are a faulting strobe that arrives together with a status write, and a strobe that arrives while enable is low, where the strobe must have no effect. The stimulus drives these collisions on purpose, along with mixed request/idle patterns and stuck-low toggles during an open connection. A behavioural reference model then checks every output on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int NUM_CH = 2;
  typedef logic [NUM_CH-1:0] ch_mask_t;

  function automatic ch_mask_t grant_of(input ch_mask_t req, input ch_mask_t idle,
                                        input logic force_in);
    return force_in ? req : (req & idle);
  endfunction

  function automatic logic refused(input ch_mask_t req, input ch_mask_t idle,
                                   input logic force_in);
    return !force_in && (|(req & ~idle));
  endfunction
endpackage

// File: rtl/dsc_chan_slice.sv
module dsc_chan_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic take,
  input  logic grant,
  output logic closed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       closed <= 1'b0;
    else if (!enable) closed <= 1'b0;
    else if (take)    closed <= grant;
  end
endmodule

// File: rtl/dsc_fault_track.sv
module dsc_fault_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic take,
  input  logic refuse,
  input  logic clear_wr,
  output logic ok_bit,
  output logic pulse
);
  logic set_fail, set_ok;
  assign set_fail = enable && take && refuse;
  assign set_ok   = enable && ((take && !refuse) || clear_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_bit <= 1'b1;
      pulse  <= 1'b0;
    end else if (!enable) begin
      ok_bit <= 1'b1;
      pulse  <= 1'b0;
    end else begin
      pulse <= set_fail;
      if (set_fail)    ok_bit <= 1'b0;
      else if (set_ok) ok_bit <= 1'b1;
    end
  end
endmodule

// File: rtl/dsc_buf_gate.sv
module dsc_buf_gate #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] closed,
  input  logic              stuck_low,
  output logic              active,
  output logic              ready_low
);
  assign active    = (|closed) && !stuck_low;
  assign ready_low = !active;
endmodule

// File: rtl/dsc_link_ctrl.sv
module dsc_link_ctrl
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_req,
  input  logic [1:0] chan_idle,
  input  logic       force_conn,
  input  logic       stuck_low,
  input  logic       reg0_wr,
  output logic [1:0] sw_en,
  output logic       buf_active,
  output logic       ready_pull_low,
  output logic       conn_ok,
  output logic       fault_pulse
);
  ch_mask_t grant_w;
  logic     refuse_w;
  logic     take_w;

  assign grant_w  = grant_of(cmd_req, chan_idle, force_conn);
  assign refuse_w = refused(cmd_req, chan_idle, force_conn);
  assign take_w   = cmd_valid && enable;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dsc_chan_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .take   (take_w),
      .grant  (grant_w[i]),
      .closed (sw_en[i])
    );
  end

  dsc_fault_track u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .take     (take_w),
    .refuse   (refuse_w),
    .clear_wr (reg0_wr),
    .ok_bit   (conn_ok),
    .pulse    (fault_pulse)
  );

  dsc_buf_gate #(.NUM_CH(NUM_CH)) u_buf (
    .closed    (sw_en),
    .stuck_low (stuck_low),
    .active    (buf_active),
    .ready_low (ready_pull_low)
  );
endmodule

// File: rtl/dsc_link_ctrl_chk.sv
module dsc_link_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       cmd_valid,
  input logic [1:0] cmd_req,
  input logic [1:0] chan_idle,
  input logic       force_conn,
  input logic       stuck_low,
  input logic [1:0] sw_en,
  input logic       buf_active,
  input logic       ready_pull_low,
  input logic       conn_ok,
  input logic       fault_pulse
);
  assert_gate_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && enable && !force_conn) |=> ((sw_en & ~$past(chan_idle)) == 2'b00));

  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && enable && force_conn) |=> (sw_en == $past(cmd_req) && !fault_pulse));

  assert_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && enable && !force_conn && |(cmd_req & ~chan_idle)) |=> (!conn_ok && fault_pulse));

  assert_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_active |-> (sw_en != 2'b00 && !stuck_low));

  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pull_low != buf_active);

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sw_en == 2'b00 && conn_ok && !fault_pulse));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cmd_valid) |=> $stable(sw_en));
endmodule

bind dsc_link_ctrl dsc_link_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid),
  .cmd_req(cmd_req), .chan_idle(chan_idle), .force_conn(force_conn),
  .stuck_low(stuck_low), .sw_en(sw_en), .buf_active(buf_active),
  .ready_pull_low(ready_pull_low), .conn_ok(conn_ok), .fault_pulse(fault_pulse)
);

// File: tb/dsc_link_ctrl_tb.sv
module dsc_link_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cmd_valid = 1'b0, force_conn = 1'b0, stuck_low = 1'b0, reg0_wr = 1'b0;
  logic [1:0] cmd_req = 2'b00, chan_idle = 2'b11;
  logic [1:0] sw_en;
  logic buf_active, ready_pull_low, conn_ok, fault_pulse;

  int checks = 0, errors = 0;
  int m_sw = 0, m_ok = 1, m_pulse = 0;

  always #4 clk = ~clk;

  dsc_link_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid),
    .cmd_req(cmd_req), .chan_idle(chan_idle), .force_conn(force_conn),
    .stuck_low(stuck_low), .reg0_wr(reg0_wr), .sw_en(sw_en),
    .buf_active(buf_active), .ready_pull_low(ready_pull_low),
    .conn_ok(conn_ok), .fault_pulse(fault_pulse)
  );

  // Behavioural reference: integers, channel by channel.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw <= 0; m_ok <= 1; m_pulse <= 0;
    end else if (!enable) begin
      m_sw <= 0; m_ok <= 1; m_pulse <= 0;
    end else begin
      int bad, nsw;
      bad = 0; nsw = m_sw;
      if (cmd_valid) begin
        nsw = 0;
        for (int c = 0; c < 2; c++) begin
          if (cmd_req[c]) begin
            if (force_conn || chan_idle[c]) nsw += (1 << c);
            else bad = 1;
          end
        end
      end
      m_sw <= nsw;
      m_pulse <= bad;
      if (bad) m_ok <= 0;
      else if (cmd_valid || reg0_wr) m_ok <= 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_buf;
    exp_buf = (m_sw != 0 && !stuck_low) ? 1 : 0;
    check("R1/R2/R3 sw_en", int'(sw_en), m_sw);
    check("R6 buf_active", int'(buf_active), exp_buf);
    check("R7 ready_pull_low", int'(ready_pull_low), 1 - exp_buf);
    check("R9 conn_ok", int'(conn_ok), m_ok);
    check("R5 fault_pulse", int'(fault_pulse), m_pulse);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(input logic [1:0] req, input logic [1:0] idle, input logic frc);
    cmd_valid = 1'b1; cmd_req = req; chan_idle = idle; force_conn = frc;
    tick();
    cmd_valid = 1'b0; force_conn = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state
    check("R11 sw_en", int'(sw_en), 0);
    check("R11 ready", int'(ready_pull_low), 1);
    check("R11 conn_ok", int'(conn_ok), 1);
    rst_n = 1'b1; enable = 1'b1;
    tick();
    // R1 each combination, all idle
    cmd(2'b01, 2'b11, 0); check("R1 ch1 only", int'(sw_en), 1);
    cmd(2'b10, 2'b11, 0); check("R1 ch2 only", int'(sw_en), 2);
    cmd(2'b11, 2'b11, 0); check("R1 both", int'(sw_en), 3);
    check("R7 ready released", int'(ready_pull_low), 0);
    cmd(2'b00, 2'b11, 0); check("R1 none", int'(sw_en), 0);
    // R2/R5 busy channel refused
    cmd(2'b01, 2'b10, 0);
    check("R2 busy refused", int'(sw_en), 0);
    check("R5 pulse", int'(fault_pulse), 1);
    check("R5 ok low", int'(conn_ok), 0);
    tick(); check("R5 pulse one cycle", int'(fault_pulse), 0);
    // R9 status write clears
    reg0_wr = 1'b1; tick(); reg0_wr = 1'b0;
    check("R9 cleared by write", int'(conn_ok), 1);
    // R3 mixed
    cmd(2'b11, 2'b10, 0); check("R3 only idle connected", int'(sw_en), 2);
    // R9 successful command clears
    cmd(2'b10, 2'b10, 0); check("R9 cleared by success", int'(conn_ok), 1);
    // R10 hold while idle changes
    chan_idle = 2'b00; tick(); tick();
    check("R10 hold", int'(sw_en), 2);
    // R6 stuck low
    stuck_low = 1'b1; #1; check("R6 stuck blocks", int'(buf_active), 0);
    tick(); stuck_low = 1'b0; #1;
    check("R6 recovered", int'(buf_active), 1);
    // R4 force
    cmd(2'b11, 2'b00, 1);
    check("R4 forced both", int'(sw_en), 3);
    check("R4 no fault", int'(fault_pulse), 0);
    // R9 fault wins over write
    reg0_wr = 1'b1; cmd(2'b01, 2'b00, 0); reg0_wr = 1'b0;
    check("R9 fault wins", int'(conn_ok), 0);
    // R8 disable
    cmd(2'b11, 2'b11, 0);
    enable = 1'b0; tick();
    check("R8 sw cleared", int'(sw_en), 0);
    check("R8 ok default", int'(conn_ok), 1);
    cmd(2'b11, 2'b11, 1); check("R8 cmd ignored", int'(sw_en), 0);
    cmd(2'b01, 2'b00, 0); check("R8 no fault when disabled", int'(fault_pulse), 0);
    enable = 1'b1; tick();
    // sweep all patterns
    for (int p = 0; p < 32; p++) begin
      cmd(p[1:0], p[3:2], p[4]);
      stuck_low = p[0] ^ p[3];
      reg0_wr = p[2] & p[4];
      tick();
      stuck_low = 1'b0; reg0_wr = 1'b0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule